// File: doc/BRIEF.md
# Audio Transmit Sample Queue with Underrun Repeat

This block sits between a memory-side supplier (a CPU or a DMA engine) and an I2S-style serializer. The supplier pushes audio samples into a small first-in first-out store. The serializer pulses a request once per frame slot, and the block answers with the next queued sample on a registered output. The block also asks the DMA engine for more data whenever enough of the store is free.

If a slot request arrives while the store is empty, the block raises a sticky underrun flag. It then presents the most recently delivered sample again. The cause does not matter: the supplier may be late, or the data may have run out. Repetition continues for every later request until new data is queued or the unit enable is cleared. Software clears the flag. An interrupt output is driven while the flag and its enable are both set.

Clearing the unit enable empties the store and zeroes the held sample. While the unit is disabled, writes and slot requests are ignored. Serial bit timing and clock generation are outside this block.

Top module: `aud_tx_fifo`

## Requirements
- R1: After a synchronous reset, `slot_data` is 0, `ur_flag` is 0, `irq` is 0 and the store is empty.
- R2: Samples are delivered in write order. A request in cycle N, with the store not empty, puts the oldest sample on `slot_data` after the clock edge that ends cycle N.
- R3: A request while the store is empty sets `ur_flag` after that edge and leaves `slot_data` at the last delivered value.
- R4: If no sample has been delivered since the unit was enabled, the repeated value is 0.
- R5: Repetition continues for any number of requests. Once a sample is written, the next request takes it from the store. `ur_flag` stays set through this.
- R6: `ur_clr` clears `ur_flag`. If `ur_clr` and an underrun occur in the same cycle, the flag is set.
- R7: `irq` is 1 exactly when `ur_flag` and `ur_ie` are both 1.
- R8: `dreq` is 1 when `en` is 1 and the free entry count (DEPTH minus fill) is at least `thresh`. With `thresh` = 0 it is 1 whenever the unit is enabled.
- R9: While `en` is 0, the store is emptied, `slot_data` is forced to 0, `dreq` is 0, and writes and requests are ignored.
- R10: A write while the store holds DEPTH samples is dropped, even if a request pops in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Unit enable |
| wr_valid | input | 1 | Write strobe for one sample |
| wr_data | input | DW | Sample to queue |
| slot_req | input | 1 | Serializer request for the next slot sample |
| slot_data | output | DW | Sample presented to the serializer |
| thresh | input | $clog2(DEPTH)+1 | Free-space threshold for the DMA request |
| ur_ie | input | 1 | Underrun interrupt enable |
| ur_clr | input | 1 | Clear for the underrun flag |
| ur_flag | output | 1 | Sticky underrun status |
| irq | output | 1 | Underrun interrupt |
| dreq | output | 1 | Transmit DMA request |

## Verification
The hardest case to reach is the boundary where underrun recovery meets other events. New data arrives during an underrun, a clear collides with a fresh underrun, and a disable/re-enable must zero the repeated value. The stimulus table drives the store empty on purpose and keeps requesting. It then writes a single sample, issues the clear in the same cycle as an empty request, and toggles the enable before requesting again. A directed run fills the store to its limit, drops one extra write, and drains it into underrun.

// File: rtl/atf_pkg.sv
package atf_pkg;

    typedef enum logic [1:0] {
        ACT_NONE   = 2'd0,
        ACT_POP    = 2'd1,
        ACT_REPEAT = 2'd2
    } slot_act_e;

    function automatic slot_act_e pick_act(input logic en, input logic req, input logic empty);
        if (!en || !req) return ACT_NONE;
        if (empty)       return ACT_REPEAT;
        return ACT_POP;
    endfunction

endpackage

// File: rtl/atf_store.sv
module atf_store #(
    parameter int DW    = 16,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic          push,
    input  logic          pop,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] head,
    output logic [CW-1:0] cnt
);
    localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;

    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (push) wr_ptr <= (wr_ptr == LAST_IDX) ? '0 : wr_ptr + 1'b1;
            if (pop)  rd_ptr <= (rd_ptr == LAST_IDX) ? '0 : rd_ptr + 1'b1;
            case ({push, pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    assign head = mem[rd_ptr];

endmodule

// File: rtl/atf_slot.sv
module atf_slot
    import atf_pkg::*;
#(
    parameter int DW = 16,
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          req,
    input  logic [CW-1:0] cnt,
    input  logic [DW-1:0] head,
    input  logic          ur_clr,
    output logic          pop,
    output logic [DW-1:0] slot_data,
    output logic          ur_flag
);
    slot_act_e act;

    always_comb act = pick_act(en, req, cnt == '0);
    assign pop = (act == ACT_POP);

    // Held sample doubles as the output: an underrun simply leaves it alone.
    always_ff @(posedge clk) begin
        if (rst || !en)          slot_data <= '0;
        else if (act == ACT_POP) slot_data <= head;
    end

    always_ff @(posedge clk) begin
        if (rst)                    ur_flag <= 1'b0;
        else if (act == ACT_REPEAT) ur_flag <= 1'b1;
        else if (ur_clr)            ur_flag <= 1'b0;
    end

endmodule

// File: rtl/atf_dreq.sv
module atf_dreq #(
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH) + 1
) (
    input  logic          en,
    input  logic [CW-1:0] cnt,
    input  logic [CW-1:0] thresh,
    output logic          dreq
);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    logic [CW-1:0] free_ent;

    assign free_ent = FULL_CNT - cnt;
    assign dreq     = en && (free_ent >= thresh);

endmodule

// File: rtl/aud_tx_fifo.sv
module aud_tx_fifo #(
    parameter int DW    = 16,
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH) + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          wr_valid,
    input  logic [DW-1:0] wr_data,
    input  logic          slot_req,
    output logic [DW-1:0] slot_data,
    input  logic [CW-1:0] thresh,
    input  logic          ur_ie,
    input  logic          ur_clr,
    output logic          ur_flag,
    output logic          irq,
    output logic          dreq
);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    logic [CW-1:0] cnt;
    logic [DW-1:0] head;
    logic          push, pop;

    assign push = en && wr_valid && (cnt != FULL_CNT);

    atf_store #(.DW(DW), .DEPTH(DEPTH)) store_i (
        .clk(clk), .rst(rst), .flush(!en), .push(push), .pop(pop),
        .wdata(wr_data), .head(head), .cnt(cnt)
    );

    atf_slot #(.DW(DW), .CW(CW)) slot_i (
        .clk(clk), .rst(rst), .en(en), .req(slot_req), .cnt(cnt),
        .head(head), .ur_clr(ur_clr), .pop(pop),
        .slot_data(slot_data), .ur_flag(ur_flag)
    );

    atf_dreq #(.DEPTH(DEPTH)) dreq_i (
        .en(en), .cnt(cnt), .thresh(thresh), .dreq(dreq)
    );

    assign irq = ur_flag && ur_ie;

endmodule

// File: rtl/aud_tx_fifo_chk.sv
module aud_tx_fifo_chk #(
    parameter int DW    = 16,
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH) + 1
) (
    input logic          clk,
    input logic          rst,
    input logic          en,
    input logic          slot_req,
    input logic          ur_clr,
    input logic          ur_flag,
    input logic [DW-1:0] slot_data,
    input logic [CW-1:0] cnt,
    input logic          dreq
);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    a_r3_flag_set: assert property (@(posedge clk) disable iff (rst)
        (en && slot_req && cnt == '0) |=> ur_flag);

    a_r3_hold_sample: assert property (@(posedge clk) disable iff (rst)
        (en && slot_req && cnt == '0) |=> $stable(slot_data));

    a_r6_sticky: assert property (@(posedge clk) disable iff (rst)
        (ur_flag && !ur_clr) |=> ur_flag);

    a_r9_flush: assert property (@(posedge clk) disable iff (rst)
        !en |=> (cnt == '0 && slot_data == '0));

    a_r8_gated: assert property (@(posedge clk) disable iff (rst)
        !en |-> !dreq);

    a_r10_no_overflow: assert property (@(posedge clk) disable iff (rst)
        cnt <= FULL_CNT);

endmodule

bind aud_tx_fifo aud_tx_fifo_chk #(.DW(DW), .DEPTH(DEPTH)) chk_i (
    .clk(clk), .rst(rst), .en(en), .slot_req(slot_req), .ur_clr(ur_clr),
    .ur_flag(ur_flag), .slot_data(slot_data), .cnt(cnt), .dreq(dreq)
);

// File: tb/aud_tx_fifo_tb_top.sv
module aud_tx_fifo_tb_top;
    localparam int DW    = 16;
    localparam int DEPTH = 16;
    localparam int CW    = $clog2(DEPTH) + 1;

    logic          clk = 1'b0;
    logic          rst, en, wr_valid, slot_req, ur_ie, ur_clr;
    logic [DW-1:0] wr_data;
    logic [CW-1:0] thresh;
    logic [DW-1:0] slot_data;
    logic          ur_flag, irq, dreq;

    int n_vec  = 0;
    int n_fail = 0;

    always #5ns clk = ~clk;

    aud_tx_fifo #(.DW(DW), .DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst(rst), .en(en), .wr_valid(wr_valid), .wr_data(wr_data),
        .slot_req(slot_req), .slot_data(slot_data), .thresh(thresh),
        .ur_ie(ur_ie), .ur_clr(ur_clr), .ur_flag(ur_flag), .irq(irq), .dreq(dreq)
    );

    typedef struct packed {
        logic          en;
        logic          wr;
        logic [15:0]   wd;
        logic          req;
        logic          clr;
        logic          ie;
        logic [4:0]    th;
        logic [15:0]   x_data;
        logic          x_ur;
        logic          x_dreq;
        logic          x_irq;
    } vec_t;

    localparam int NV = 21;
    localparam vec_t VT [NV] = '{
        '{1'b0,1'b1,16'hAAAA,1'b0,1'b0,1'b0,5'd8,  16'h0000,1'b0,1'b0,1'b0}, // 0  R9 write ignored
        '{1'b1,1'b0,16'h0000,1'b1,1'b0,1'b0,5'd8,  16'h0000,1'b1,1'b1,1'b0}, // 1  R4 zero repeat
        '{1'b1,1'b0,16'h0000,1'b0,1'b1,1'b1,5'd8,  16'h0000,1'b0,1'b1,1'b0}, // 2  R6 clear
        '{1'b1,1'b1,16'h1111,1'b0,1'b0,1'b1,5'd8,  16'h0000,1'b0,1'b1,1'b0}, // 3  R2
        '{1'b1,1'b1,16'h2222,1'b0,1'b0,1'b1,5'd8,  16'h0000,1'b0,1'b1,1'b0}, // 4  R2
        '{1'b1,1'b1,16'h3333,1'b0,1'b0,1'b1,5'd8,  16'h0000,1'b0,1'b1,1'b0}, // 5  R2
        '{1'b1,1'b0,16'h0000,1'b1,1'b0,1'b1,5'd8,  16'h1111,1'b0,1'b1,1'b0}, // 6  R2
        '{1'b1,1'b1,16'h4444,1'b1,1'b0,1'b1,5'd8,  16'h2222,1'b0,1'b1,1'b0}, // 7  R2
        '{1'b1,1'b0,16'h0000,1'b1,1'b0,1'b1,5'd8,  16'h3333,1'b0,1'b1,1'b0}, // 8  R2
        '{1'b1,1'b0,16'h0000,1'b1,1'b0,1'b1,5'd8,  16'h4444,1'b0,1'b1,1'b0}, // 9  R2
        '{1'b1,1'b0,16'h0000,1'b1,1'b0,1'b1,5'd8,  16'h4444,1'b1,1'b1,1'b1}, // 10 R3
        '{1'b1,1'b0,16'h0000,1'b1,1'b0,1'b1,5'd8,  16'h4444,1'b1,1'b1,1'b1}, // 11 R5
        '{1'b1,1'b0,16'h0000,1'b1,1'b0,1'b0,5'd8,  16'h4444,1'b1,1'b1,1'b0}, // 12 R7
        '{1'b1,1'b1,16'h5555,1'b0,1'b0,1'b0,5'd8,  16'h4444,1'b1,1'b1,1'b0}, // 13 R5
        '{1'b1,1'b0,16'h0000,1'b1,1'b0,1'b0,5'd8,  16'h5555,1'b1,1'b1,1'b0}, // 14 R5
        '{1'b1,1'b0,16'h0000,1'b1,1'b1,1'b0,5'd8,  16'h5555,1'b1,1'b1,1'b0}, // 15 R6 set wins
        '{1'b1,1'b0,16'h0000,1'b0,1'b1,1'b0,5'd8,  16'h5555,1'b0,1'b1,1'b0}, // 16 R6
        '{1'b1,1'b0,16'h0000,1'b0,1'b0,1'b0,5'd16, 16'h5555,1'b0,1'b1,1'b0}, // 17 R8
        '{1'b1,1'b1,16'h6666,1'b0,1'b0,1'b0,5'd16, 16'h5555,1'b0,1'b0,1'b0}, // 18 R8
        '{1'b0,1'b0,16'h0000,1'b1,1'b0,1'b0,5'd16, 16'h0000,1'b0,1'b0,1'b0}, // 19 R9 flush
        '{1'b1,1'b0,16'h0000,1'b1,1'b0,1'b0,5'd16, 16'h0000,1'b1,1'b1,1'b0}  // 20 R4 after re-enable
    };

    function automatic string tag_of(input int i);
        case (i)
            0, 19:                 return "R9";
            1, 20:                 return "R4";
            2, 15, 16:             return "R6";
            10:                    return "R3";
            11, 13, 14:            return "R5";
            12:                    return "R7";
            17, 18:                return "R8";
            default:               return "R2";
        endcase
    endfunction

    task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic idle();
        wr_valid = 1'b0; slot_req = 1'b0; ur_clr = 1'b0; wr_data = '0;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #2ms;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; en = 1'b0; ur_ie = 1'b0; thresh = 5'd8;
        idle();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R1", "slot_data", 32'(slot_data), 32'h0);
        check("R1", "ur_flag", 32'(ur_flag), 32'h0);
        check("R1", "irq", 32'(irq), 32'h0);

        for (int i = 0; i < NV; i++) begin
            en = VT[i].en; wr_valid = VT[i].wr; wr_data = VT[i].wd;
            slot_req = VT[i].req; ur_clr = VT[i].clr; ur_ie = VT[i].ie;
            thresh = VT[i].th;
            step();
            check(tag_of(i), $sformatf("v%0d data", i), 32'(slot_data), 32'(VT[i].x_data));
            check(tag_of(i), $sformatf("v%0d ur", i), 32'(ur_flag), 32'(VT[i].x_ur));
            check(tag_of(i), $sformatf("v%0d dreq", i), 32'(dreq), 32'(VT[i].x_dreq));
            check(tag_of(i), $sformatf("v%0d irq", i), 32'(irq), 32'(VT[i].x_irq));
        end

        // R1: reset mid-run clears the flag and the held sample
        idle(); ur_ie = 1'b1; rst = 1'b1;
        step();
        rst = 1'b0;
        check("R1", "ur_flag after reset", 32'(ur_flag), 32'h0);
        check("R1", "slot_data after reset", 32'(slot_data), 32'h0);

        // R10: fill to DEPTH plus one extra write, then drain
        en = 1'b1; thresh = 5'd0;
        for (int k = 0; k <= DEPTH; k++) begin
            wr_valid = 1'b1; wr_data = 16'h0100 + 16'(k);
            step();
        end
        idle();
        check("R8", "dreq full thr0", 32'(dreq), 32'h1);
        thresh = 5'd1;
        #1ns;
        check("R8", "dreq full thr1", 32'(dreq), 32'h0);
        // R10: write while full and popping is still dropped
        slot_req = 1'b1; wr_valid = 1'b1; wr_data = 16'hBEEF;
        step();
        idle();
        check("R2", "first out", 32'(slot_data), 32'h0100);
        for (int k = 1; k < DEPTH; k++) begin
            slot_req = 1'b1;
            step();
            check("R2", $sformatf("drain %0d", k), 32'(slot_data), 32'(16'h0100 + 16'(k)));
        end
        check("R10", "no underrun yet", 32'(ur_flag), 32'h0);
        slot_req = 1'b1;
        step();
        idle();
        check("R10", "extra writes dropped", 32'(slot_data), 32'h010F);
        check("R3", "underrun after drain", 32'(ur_flag), 32'h1);
        check("R7", "irq with ie", 32'(irq), 32'h1);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule